// File: doc/BRIEF.md
# Two-Register Serial Write Slave for a Converter Controller

This block is the receive side of an I2C target that lets a bus controller program a small data converter. SCL and SDA are oversampled on a fast system clock, so the block has no clock domain of its own. It finds START, repeated START and STOP conditions on the synchronized lines. It shifts in an address byte and compares the 7-bit address with a parameter. When the address matches and the direction bit asks for a write, it acknowledges and then takes the data bytes that follow.

The most significant bit of each data byte selects its destination. When that bit is one, the byte updates the setup fields: a reference selection, a clock source flag and a polarity flag. It also carries a control bit that can return the configuration register to its defaults. When that bit is zero, the low seven bits of the byte become the configuration register. The first two data bytes of a frame are applied, in whatever order they arrive. Any later byte is acknowledged and dropped. Each register update is announced by a one-cycle strobe so that downstream logic can capture the new fields.

Top module: `cfg_wr_slave`

## Requirements
- R1: After the synchronous reset, ref_sel is 000, ext_clk and bipolar are 0, cfg_bits is 0, and sda_oe, setup_wr and cfg_wr are all 0.
- R2: When the address byte (7 address bits MSB first, then a direction bit of 0 for write) matches SLAVE_ADDR, sda_oe is 1 during the high phase of the ninth SCL pulse. It is 0 again after the SCL falling edge that ends that pulse, and it changes only while SCL is low.
- R3: An address byte that does not match, or one whose direction bit is 1, is not acknowledged. No data byte that follows it before the next START is acknowledged or changes any output.
- R4: An applied data byte with bit 7 = 1 sets ref_sel = bits 6:4, ext_clk = bit 3 and bipolar = bit 2. It raises setup_wr for exactly one cycle. Bit 0 has no effect, and the setup outputs change only together with setup_wr.
- R5: An applied data byte with bit 7 = 0 sets cfg_bits = bits 6:0 and raises cfg_wr for exactly one cycle. cfg_bits changes only together with cfg_wr.
- R6: A setup byte with bit 1 = 0 also clears cfg_bits to 0 and raises cfg_wr in the same cycle as setup_wr. With bit 1 = 1, cfg_bits is left unchanged.
- R7: In a matched write frame every data byte is acknowledged. The first two are applied in arrival order, whichever register each one selects.
- R8: A third or later data byte in one frame is acknowledged, but it changes no output and raises no strobe.
- R9: After a STOP, clocked bits are ignored until a START. A repeated START restarts address reception, so a new matched address is followed by applied data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| ref_sel | output | 3 | Reference selection field |
| ext_clk | output | 1 | Clock source flag, 1 = external |
| bipolar | output | 1 | Polarity flag, 1 = bipolar |
| cfg_bits | output | 7 | Configuration register contents |
| setup_wr | output | 1 | One-cycle pulse when the setup fields update |
| cfg_wr | output | 1 | One-cycle pulse when cfg_bits updates |

## Verification
A wrong bit counter or a wrong state shows first on sda_oe. The acknowledge goes missing, or appears on the wrong SCL pulse, within the same byte. A wrong byte index or routing decision shows on the field outputs and strobe counts a few system cycles after the ninth falling SCL edge, and it is compared against a bench model at the end of every frame. Lost START or STOP tracking shows in the frames that follow, as acknowledges to bits clocked without a START or as data ignored after a repeated START.

// File: rtl/cfg_wr_pkg.sv
package cfg_wr_pkg;

    localparam int ADDR_W     = 7;
    localparam int BYTE_W     = 8;
    localparam int CFG_W      = BYTE_W - 1;
    localparam int REF_W      = 3;
    localparam int BIT_CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_ADDR_ACK,
        RX_DATA,
        RX_DATA_ACK
    } rx_state_t;

    typedef struct packed {
        logic [REF_W-1:0] ref_sel;
        logic             ext_clk;
        logic             bipolar;
    } setup_t;

    localparam setup_t SETUP_DEFAULT = '{ref_sel: '0, ext_clk: 1'b0, bipolar: 1'b0};
    localparam logic [CFG_W-1:0] CFG_DEFAULT = '0;

    function automatic logic sel_is_setup(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1];
    endfunction

    function automatic setup_t unpack_setup(input logic [BYTE_W-1:0] b);
        setup_t s;
        s.ref_sel = b[6:4];
        s.ext_clk = b[3];
        s.bipolar = b[2];
        return s;
    endfunction

    function automatic logic keeps_cfg(input logic [BYTE_W-1:0] b);
        return b[1];
    endfunction

endpackage

// File: rtl/cfg_wr_sync.sv
module cfg_wr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_s, sda_s, scl_q, sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign sda_lvl   = sda_s;
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfg_wr_rx.sv
module cfg_wr_rx
    import cfg_wr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h34,
    parameter int                MAX_BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data
);
    localparam int IDX_W = $clog2(MAX_BYTES + 1);
    localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);
    localparam logic [IDX_W-1:0]     IDX_MAX = IDX_W'(MAX_BYTES);

    rx_state_t             state;
    logic [BIT_CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0]     shreg;
    logic [IDX_W-1:0]      byte_idx;
    logic                  shifting;
    logic                  byte_done;
    logic                  addr_hit;

    assign shifting  = (state == RX_ADDR) || (state == RX_DATA);
    assign byte_done = shifting && scl_fall && (bit_cnt == FULL);
    assign addr_hit  = (shreg[BYTE_W-1:1] == SLAVE_ADDR) && !shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RX_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            byte_idx  <= '0;
            sda_oe    <= 1'b0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (start_det) begin
                state    <= RX_ADDR;
                bit_cnt  <= '0;
                byte_idx <= '0;
                sda_oe   <= 1'b0;
            end else if (stop_det) begin
                state  <= RX_IDLE;
                sda_oe <= 1'b0;
            end else begin
                if (shifting && scl_rise && bit_cnt != FULL) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                unique case (state)
                    RX_ADDR: begin
                        if (byte_done) begin
                            if (addr_hit) begin
                                sda_oe <= 1'b1;
                                state  <= RX_ADDR_ACK;
                            end else begin
                                state <= RX_IDLE;
                            end
                        end
                    end
                    RX_DATA: begin
                        if (byte_done) begin
                            sda_oe <= 1'b1;
                            state  <= RX_DATA_ACK;
                            if (byte_idx != IDX_MAX) begin
                                byte_vld  <= 1'b1;
                                byte_data <= shreg;
                                byte_idx  <= byte_idx + 1'b1;
                            end
                        end
                    end
                    RX_ADDR_ACK, RX_DATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= RX_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_wr_regs.sv
module cfg_wr_regs
    import cfg_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output setup_t            setup_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              setup_wr,
    output logic              cfg_wr
);
    logic is_setup;
    logic clr_cfg;

    assign is_setup = sel_is_setup(byte_data);
    assign clr_cfg  = is_setup && !keeps_cfg(byte_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q  <= SETUP_DEFAULT;
            cfg_q    <= CFG_DEFAULT;
            setup_wr <= 1'b0;
            cfg_wr   <= 1'b0;
        end else begin
            setup_wr <= 1'b0;
            cfg_wr   <= 1'b0;
            if (byte_vld) begin
                if (is_setup) begin
                    setup_q  <= unpack_setup(byte_data);
                    setup_wr <= 1'b1;
                    if (clr_cfg) begin
                        cfg_q  <= CFG_DEFAULT;
                        cfg_wr <= 1'b1;
                    end
                end else begin
                    cfg_q  <= byte_data[CFG_W-1:0];
                    cfg_wr <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfg_wr_slave.sv
module cfg_wr_slave
    import cfg_wr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h34,
    parameter int                SYNC_STAGES = 2,
    parameter int                MAX_BYTES   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic [REF_W-1:0]       ref_sel,
    output logic                   ext_clk,
    output logic                   bipolar,
    output logic [CFG_W-1:0]       cfg_bits,
    output logic                   setup_wr,
    output logic                   cfg_wr
);
    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_data;
    setup_t            setup_q;

    cfg_wr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfg_wr_rx #(.SLAVE_ADDR(SLAVE_ADDR), .MAX_BYTES(MAX_BYTES)) u_rx (
        .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe), .byte_vld(byte_vld), .byte_data(byte_data)
    );

    cfg_wr_regs u_regs (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
        .setup_q(setup_q), .cfg_q(cfg_bits),
        .setup_wr(setup_wr), .cfg_wr(cfg_wr)
    );

    assign ref_sel = setup_q.ref_sel;
    assign ext_clk = setup_q.ext_clk;
    assign bipolar = setup_q.bipolar;
endmodule

// File: rtl/cfg_wr_chk.sv
module cfg_wr_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input logic [2:0] ref_sel,
    input logic       ext_clk,
    input logic       bipolar,
    input logic [6:0] cfg_bits,
    input logic       setup_wr,
    input logic       cfg_wr
);
    // R2
    ack_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R4
    setup_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        setup_wr |=> !setup_wr);

    // R5
    cfg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !cfg_wr);

    // R4
    setup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !setup_wr |-> $stable({ref_sel, ext_clk, bipolar}));

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |-> $stable(cfg_bits));

    // R6
    cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (setup_wr && cfg_wr) |-> (cfg_bits == 7'd0));
endmodule

bind cfg_wr_slave cfg_wr_chk u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
    .ref_sel(ref_sel), .ext_clk(ext_clk), .bipolar(bipolar),
    .cfg_bits(cfg_bits), .setup_wr(setup_wr), .cfg_wr(cfg_wr)
);

// File: tb/sim_cfg_wr_slave.sv
`timescale 1ns/1ps
module sim_cfg_wr_slave;
    localparam logic [6:0] ADDR = 7'h34;
    localparam int Q = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_i, sda_oe, ext_clk, bipolar, setup_wr, cfg_wr;
    logic [2:0] ref_sel;
    logic [6:0] cfg_bits;

    int n_chk = 0, n_fail = 0, n_su = 0, n_cf = 0, cyc = 0;
    logic [2:0] m_ref = '0;
    logic m_ext = 0, m_bip = 0;
    logic [6:0] m_cfg = '0;

    always #5 clk = ~clk;
    assign sda_i = sda_m & ~sda_oe;

    cfg_wr_slave #(.SLAVE_ADDR(ADDR)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_i), .sda_oe(sda_oe),
        .ref_sel(ref_sel), .ext_clk(ext_clk), .bipolar(bipolar),
        .cfg_bits(cfg_bits), .setup_wr(setup_wr), .cfg_wr(cfg_wr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (setup_wr) n_su <= n_su + 1;
            if (cfg_wr)   n_cf <= n_cf + 1;
        end
    end

    initial begin
        wait (cyc == 180000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: act=%0d cycles exp=finish earlier", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; wq();
        sda_m = 0; wq();
        scl_m = 0; wq();
    endtask

    task automatic bus_restart();
        sda_m = 1; wq();
        scl_m = 1; wq();
        sda_m = 0; wq();
        scl_m = 0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 0; wq();
        scl_m = 1; wq();
        sda_m = 1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1; wq(); wq();
        scl_m = 0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_m = 1; wq();
        scl_m = 1; wq();
        ack = sda_oe;
        wq();
        scl_m = 0; wq();
        chk(sda_oe == 1'b0, "R2 release", int'(sda_oe), 0);
    endtask

    function automatic int exp_cfg_pulses(input logic [7:0] b);
        return (!b[7] || !b[1]) ? 1 : 0;
    endfunction

    task automatic model_apply(input logic [7:0] b);
        if (b[7]) begin
            m_ref = b[6:4]; m_ext = b[3]; m_bip = b[2];
            if (!b[1]) m_cfg = '0;
        end else begin
            m_cfg = b[6:0];
        end
    endtask

    task automatic check_state(input string tag, input int d_su, input int d_cf,
                               input int e_su, input int e_cf);
        chk(ref_sel == m_ref, {tag, " R4 ref_sel"}, int'(ref_sel), int'(m_ref));
        chk({ext_clk, bipolar} == {m_ext, m_bip}, {tag, " R4 ext/bip"},
            int'({ext_clk, bipolar}), int'({m_ext, m_bip}));
        chk(cfg_bits == m_cfg, {tag, " R5 cfg_bits"}, int'(cfg_bits), int'(m_cfg));
        chk(d_su == e_su, {tag, " R4 setup_wr count"}, d_su, e_su);
        chk(d_cf == e_cf, {tag, " R5 cfg_wr count"}, d_cf, e_cf);
    endtask

    task automatic do_xfer(input string tag, input logic [6:0] a, input logic rw, input int n,
                           input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic ack, ok;
        int su0, cf0, e_su, e_cf;
        logic [7:0] v;
        ok = (a == ADDR) && !rw;
        su0 = n_su; cf0 = n_cf; e_su = 0; e_cf = 0;
        bus_start();
        send_byte({a, rw}, ack);
        chk(ack == ok, ok ? {tag, " R2 addr ack"} : {tag, " R3 addr nack"}, int'(ack), int'(ok));
        for (int i = 0; i < n; i++) begin
            v = (i == 0) ? b0 : (i == 1) ? b1 : b2;
            send_byte(v, ack);
            chk(ack == ok, (i >= 2) ? {tag, " R8 ack"} : ok ? {tag, " R7 ack"} : {tag, " R3 data nack"},
                int'(ack), int'(ok));
            if (ok && i < 2) begin
                model_apply(v);
                e_su += v[7] ? 1 : 0;
                e_cf += exp_cfg_pulses(v);
            end
        end
        bus_stop();
        repeat (6) @(negedge clk);
        check_state(tag, n_su - su0, n_cf - cf0, e_su, e_cf);
    endtask

    initial begin
        logic ack;
        logic [6:0] a;
        logic rw;
        int n;
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({ref_sel, ext_clk, bipolar, cfg_bits} == '0, "R1 fields", int'({ref_sel, ext_clk, bipolar, cfg_bits}), 0);
        chk({sda_oe, setup_wr, cfg_wr} == '0, "R1 controls", int'({sda_oe, setup_wr, cfg_wr}), 0);

        // R7 setup then configuration; bit0 = 0, keep bit = 1
        do_xfer("R7 su-cfg", ADDR, 0, 2, 8'hD6, 8'h2A, 8'h00);
        // R7 configuration then setup
        do_xfer("R7 cfg-su", ADDR, 0, 2, 8'h55, 8'hB2, 8'h00);
        // R6 setup with clear bit 0 clears cfg_bits
        do_xfer("R6 clear", ADDR, 0, 1, 8'hC8, 8'h00, 8'h00);
        chk(cfg_bits == 7'd0, "R6 cfg cleared", int'(cfg_bits), 0);
        // R6 keep bit 1 leaves cfg; R4 bit0 = 1 has no effect
        do_xfer("R6 keep", ADDR, 0, 1, 8'h4F, 8'h00, 8'h00);
        do_xfer("R4 bit0", ADDR, 0, 1, 8'hAB, 8'h00, 8'h00);
        chk(cfg_bits == 7'h4F && ref_sel == 3'b010 && ext_clk && !bipolar, "R4 bit0 ignored",
            int'({ref_sel, ext_clk, bipolar, cfg_bits}), int'({3'b010, 1'b1, 1'b0, 7'h4F}));
        // R8 third byte ignored
        do_xfer("R8 three", ADDR, 0, 3, 8'h11, 8'h22, 8'h9C);
        chk(cfg_bits == 7'h22, "R8 third ignored", int'(cfg_bits), 'h22);
        // R3 wrong address and read direction
        do_xfer("R3 addr", ADDR ^ 7'h01, 0, 2, 8'h33, 8'hF0, 8'h00);
        do_xfer("R3 read", ADDR, 1, 2, 8'h44, 8'hE4, 8'h00);

        // R9 repeated START restarts address reception
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        send_byte(8'h0F, ack); model_apply(8'h0F);
        bus_restart();
        send_byte({ADDR, 1'b0}, ack);
        chk(ack == 1'b1, "R9 addr after Sr", int'(ack), 1);
        send_byte(8'h70, ack); model_apply(8'h70);
        chk(ack == 1'b1, "R9 data after Sr", int'(ack), 1);
        bus_stop();
        repeat (6) @(negedge clk);
        chk(cfg_bits == 7'h70, "R9 cfg after Sr", int'(cfg_bits), 'h70);

        // R9 bits clocked after STOP without START are ignored
        scl_m = 0; wq();
        send_byte({ADDR, 1'b0}, ack);
        chk(ack == 1'b0, "R9 no START nack", int'(ack), 0);
        send_byte(8'h12, ack);
        chk(ack == 1'b0, "R9 no START data nack", int'(ack), 0);
        bus_stop();
        repeat (6) @(negedge clk);
        chk(cfg_bits == 7'h70, "R9 no START no change", int'(cfg_bits), 'h70);

        // random frames
        for (int t = 0; t < 40; t++) begin
            a  = ($urandom % 4 == 0) ? (ADDR ^ 7'(1 + $urandom % 127)) : ADDR;
            rw = ($urandom % 6 == 0);
            n  = 1 + $urandom % 3;
            do_xfer("rand", a, rw, n, 8'($urandom), 8'($urandom), 8'($urandom));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule